// File: doc/BRIEF.md
# Stack-Capable Data Pointer with Scratchpad

This block holds a 16-bit data pointer next to a small word-addressed scratchpad memory. Each cycle a sequencer hands it one memory command (idle, read or write), one stack modifier (none, pre-decrement or post-increment), a flag that sends the read word into the pointer, and an optional ALU result with its own write-enable for the pointer. The pointer's upper field, from bit 2 upward, is the word index, so the pointer can serve as a stack pointer. Pushes are a pre-decremented write and pops a read. Post-incremented writes fill tables in ascending order.

The block's whole job is to settle, every cycle, which address the memory sees and which value the pointer holds afterwards. Three sources can compete for the pointer: the stack step, the memory load and the ALU. They are resolved by a fixed priority. The address never depends on the winner. A pre-decrement always moves the access address down one word, even when the pointer ends up taking a different value.

Top module: `ptrstk_pointer_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pointer becomes 0x0000.
- R2: The word address is pointer bits [9:2]. With stack modifier none (`stk_mode` 2'b00 or 2'b11), a read (`mem_cmd` 2'b01) or write (`mem_cmd` 2'b10) uses that address and leaves the pointer unchanged, unless a load or ALU write applies. `rd_data` shows the addressed word in the same cycle.
- R3: A write stores the pointer value held at the start of the cycle, zero-extended to 32 bits.
- R4: Post-increment (`stk_mode` 2'b10) with a read or write accesses the current address. Afterwards the field [15:2] is one higher and bits [1:0] are kept.
- R5: Pre-decrement (`stk_mode` 2'b01) with a read or write accesses the field [15:2] minus one. Afterwards the pointer holds that decremented field with bits [1:0] kept.
- R6: A read with `rd_to_ptr` high loads bits [15:0] of the read word into the pointer. Neither increment nor decrement is applied to the loaded value. A pre-decrement still selects the address read.
- R7: With `alu_we` high the pointer takes `alu_data`. This overrides both the stack step and a memory load. A pre-decrement in the same cycle still lowers the access address.
- R8: A stack modifier with `mem_cmd` idle (2'b00 or 2'b11) and `alu_we` low leaves the pointer unchanged.
- R9: Field arithmetic wraps modulo 2^14 and the address modulo 256 words. A pre-decrement from field 0 accesses word 255, and a post-increment from word 255 moves on to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_cmd | input | 2 | 00 idle, 01 read, 10 write, 11 idle |
| stk_mode | input | 2 | 00 none, 01 pre-decrement, 10 post-increment, 11 none |
| rd_to_ptr | input | 1 | A read in this cycle loads the pointer |
| alu_we | input | 1 | ALU result replaces the pointer |
| alu_data | input | 16 | ALU result |
| ptr | output | 16 | Current pointer value |
| rd_data | output | 32 | Word at the current access address |

## Verification
The scratchpad is first filled by a run of post-incremented writes that cross the top of memory, so every word holds a known value. A directed pass then pushes and pops through pre-decrement and post-increment. These cases separate the address used from the value the pointer keeps, and show whether the stored value is the old or the stepped pointer. Further cycles pair a load or an ALU write with each modifier, which shows whether the step leaks into the loaded or ALU value while the decremented address is still honoured. Modifiers with no memory command, wrap at word 0 and word 255, and a long random mix checked against a behavioural model complete the set.

// File: rtl/ptrstk_pkg.sv
// ptrstk_pkg: shared encodings for the stack-capable pointer block.
// Assumes a 2-bit command and a 2-bit modifier field from the sequencer.
package ptrstk_pkg;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'b00,
        MEM_READ  = 2'b01,
        MEM_WRITE = 2'b10,
        MEM_RSVD  = 2'b11
    } mem_cmd_e;

    typedef enum logic [1:0] {
        STK_NONE    = 2'b00,
        STK_PREDEC  = 2'b01,
        STK_POSTINC = 2'b10,
        STK_RSVD    = 2'b11
    } stk_mode_e;

endpackage

// File: rtl/ptrstk_addr_unit.sv
// ptrstk_addr_unit: derives the word address for this cycle and the stepped
// pointer value that a pre-decrement or post-increment would leave behind.
// Assumes ADDR_W <= PTR_W-2. The field wraps modulo 2^(PTR_W-2) and the
// address modulo 2^ADDR_W.
module ptrstk_addr_unit
    import ptrstk_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic [PTR_W-1:0]  cur_ptr,
    input  mem_cmd_e          cmd,
    input  stk_mode_e         mode,
    output logic              access_en,
    output logic [ADDR_W-1:0] word_addr,
    output logic              step_en,
    output logic [PTR_W-1:0]  step_ptr
);
    localparam int FLD_W = PTR_W - 2;

    logic [FLD_W-1:0] fld;
    logic [FLD_W-1:0] fld_dec;
    logic [FLD_W-1:0] fld_inc;
    logic [FLD_W-1:0] acc_fld;

    // Purpose: split the pointer and form both neighbouring word fields.
    always_comb begin
        fld     = cur_ptr[PTR_W-1:2];
        fld_dec = fld - 1'b1;
        fld_inc = fld + 1'b1;
    end

    // Purpose: pick the access field (decremented before use on pre-decrement).
    always_comb begin
        access_en = (cmd == MEM_READ) || (cmd == MEM_WRITE);
        acc_fld   = (mode == STK_PREDEC) ? fld_dec : fld;
        word_addr = acc_fld[ADDR_W-1:0];
    end

    // Purpose: stepped pointer; a step only happens alongside a memory access.
    always_comb begin
        step_en  = access_en && ((mode == STK_PREDEC) || (mode == STK_POSTINC));
        step_ptr = (mode == STK_POSTINC) ? {fld_inc, cur_ptr[1:0]}
                                         : {acc_fld, cur_ptr[1:0]};
    end

endmodule

// File: rtl/ptrstk_scratch_ram.sv
// ptrstk_scratch_ram: word-addressed scratchpad with a synchronous write and
// a combinational read of the addressed word. Contents are not reset; the
// reset input serves only the embedded checks.
module ptrstk_scratch_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store a word at the clock edge when writing.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Purpose: present the addressed word in the same cycle.
    always_comb begin
        rdata = mem[addr];
    end

    // R3: the written word is present at its address after the edge.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/ptrstk_next_sel.sv
// ptrstk_next_sel: resolves the pointer's next value from its candidate
// sources. Fixed priority, highest first: ALU result, memory load, stack
// step, hold. Assumes the caller qualifies each enable.
module ptrstk_next_sel #(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic             step_en,
    input  logic [PTR_W-1:0] step_ptr,
    input  logic             load_en,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             alu_en,
    input  logic [PTR_W-1:0] alu_ptr,
    output logic [PTR_W-1:0] next_ptr
);
    // Purpose: priority selection of the pointer's next value.
    always_comb begin
        if (alu_en) begin
            next_ptr = alu_ptr;
        end else if (load_en) begin
            next_ptr = load_ptr;
        end else if (step_en) begin
            next_ptr = step_ptr;
        end else begin
            next_ptr = cur_ptr;
        end
    end

endmodule

// File: rtl/ptrstk_pointer_unit.sv
// ptrstk_pointer_unit: 16-bit data pointer with stack modifiers over a
// word-addressed scratchpad. Each cycle takes one memory command, one stack
// modifier, a load-to-pointer flag and an optional ALU result, and decides
// the access address and the pointer's next value.
// Assumes DATA_W >= PTR_W; writes store the zero-extended pointer.
module ptrstk_pointer_unit
    import ptrstk_pkg::*;
#(
    parameter int              PTR_W   = 16,
    parameter int              DATA_W  = 32,
    parameter int              ADDR_W  = 8,
    parameter logic [PTR_W-1:0] PTR_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mem_cmd,
    input  logic [1:0]        stk_mode,
    input  logic              rd_to_ptr,
    input  logic              alu_we,
    input  logic [PTR_W-1:0]  alu_data,
    output logic [PTR_W-1:0]  ptr,
    output logic [DATA_W-1:0] rd_data
);
    mem_cmd_e          cmd;
    stk_mode_e         mode;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  next_ptr;
    logic              access_en;
    logic [ADDR_W-1:0] word_addr;
    logic              step_en;
    logic [PTR_W-1:0]  step_ptr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic              load_en;

    // Purpose: decode raw command fields into typed values.
    always_comb begin
        cmd  = mem_cmd_e'(mem_cmd);
        mode = stk_mode_e'(stk_mode);
    end

    ptrstk_addr_unit #(
        .PTR_W (PTR_W),
        .ADDR_W(ADDR_W)
    ) u_addr (
        .cur_ptr  (ptr_q),
        .cmd      (cmd),
        .mode     (mode),
        .access_en(access_en),
        .word_addr(word_addr),
        .step_en  (step_en),
        .step_ptr (step_ptr)
    );

    // Purpose: write data is the pointer as held at the start of the cycle.
    generate
        if (DATA_W > PTR_W) begin : g_wd_ext
            assign ram_wdata = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
        end else begin : g_wd_same
            assign ram_wdata = ptr_q[DATA_W-1:0];
        end
    endgenerate

    // Purpose: memory strobes and load qualification.
    always_comb begin
        ram_we  = access_en && (cmd == MEM_WRITE);
        load_en = (cmd == MEM_READ) && rd_to_ptr;
    end

    ptrstk_scratch_ram #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .addr (word_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    ptrstk_next_sel #(
        .PTR_W(PTR_W)
    ) u_sel (
        .cur_ptr (ptr_q),
        .step_en (step_en),
        .step_ptr(step_ptr),
        .load_en (load_en),
        .load_ptr(ram_rdata[PTR_W-1:0]),
        .alu_en  (alu_we),
        .alu_ptr (alu_data),
        .next_ptr(next_ptr)
    );

    // Purpose: pointer register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RST;
        end else begin
            ptr_q <= next_ptr;
        end
    end

    assign ptr     = ptr_q;
    assign rd_data = ram_rdata;

    // R1: reset value appears after a reset edge.
    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> ptr_q == PTR_RST);

    // R8: no memory command and no ALU write keeps the pointer.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_cmd == 2'b01 || mem_cmd == 2'b10) && !alu_we) |=> $stable(ptr_q));

    // R7: ALU write wins over every other source.
    assert_alu_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alu_we |=> ptr_q == $past(alu_data));

    // R6: a load keeps exactly the word read, with no step applied.
    assert_load_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == 2'b01 && rd_to_ptr && !alu_we) |=> ptr_q == $past(rd_data[PTR_W-1:0]));

    // R4: post-increment without a load or ALU write advances the field.
    assert_postinc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cmd == 2'b10 || (mem_cmd == 2'b01 && !rd_to_ptr)) && stk_mode == 2'b10 && !alu_we)
        |=> (ptr_q[PTR_W-1:2] == $past(ptr_q[PTR_W-1:2]) + 1'b1) && (ptr_q[1:0] == $past(ptr_q[1:0])));

endmodule

// File: tb/ptrstk_pointer_unit_tb.sv
module ptrstk_pointer_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mem_cmd = 2'b00;
    logic [1:0]  stk_mode = 2'b00;
    logic        rd_to_ptr = 1'b0;
    logic        alu_we = 1'b0;
    logic [15:0] alu_data = '0;
    logic [15:0] ptr;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] ptr_exp;
        bit          rd_chk;
        logic [31:0] rd_exp;
        logic [31:0] rd_act;
        string       req;
    } item_t;

    item_t sb_q[$];

    logic [31:0] mmem [256];
    logic [15:0] mptr;

    always #2 clk = ~clk;

    ptrstk_pointer_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_cmd  (mem_cmd),
        .stk_mode (stk_mode),
        .rd_to_ptr(rd_to_ptr),
        .alu_we   (alu_we),
        .alu_data (alu_data),
        .ptr      (ptr),
        .rd_data  (rd_data)
    );

    // Driver: computes expectations from the requirements, drives, pushes.
    task automatic do_op(input logic [1:0] c, input logic [1:0] m, input bit ld,
                         input bit aw, input logic [15:0] ad, input bit chk_rd,
                         input string req);
        logic [13:0] fld, acc;
        logic [7:0]  a;
        logic [31:0] word;
        logic [15:0] nxt;
        bit          act;
        item_t       it;
        fld  = mptr[15:2];
        act  = (c == 2'b01) || (c == 2'b10);
        acc  = (m == 2'b01) ? fld - 14'd1 : fld;
        a    = acc[7:0];
        word = mmem[a];
        nxt  = mptr;
        if (act && m == 2'b01) nxt = {acc, mptr[1:0]};
        if (act && m == 2'b10) nxt = {fld + 14'd1, mptr[1:0]};
        if (c == 2'b01 && ld) nxt = word[15:0];
        if (aw) nxt = ad;
        if (c == 2'b10) mmem[a] = {16'h0000, mptr};
        @(negedge clk);
        mem_cmd = c; stk_mode = m; rd_to_ptr = ld; alu_we = aw; alu_data = ad;
        #1;
        it.ptr_exp = nxt;
        it.rd_chk  = chk_rd && (c == 2'b01);
        it.rd_exp  = word;
        it.rd_act  = rd_data;
        it.req     = req;
        sb_q.push_back(it);
        mptr = nxt;
    endtask

    // Monitor: pops one item per edge and compares the results.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (ptr !== it.ptr_exp) begin
                    bad++;
                    $display("FAIL %s ptr actual=%h expected=%h", it.req, ptr, it.ptr_exp);
                end
                if (it.rd_chk) begin
                    total++;
                    if (it.rd_act !== it.rd_exp) begin
                        bad++;
                        $display("FAIL %s rd_data actual=%h expected=%h", it.req, it.rd_act, it.rd_exp);
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mptr = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        total++;
        if (ptr !== 16'h0000) begin
            bad++;
            $display("FAIL R1 ptr actual=%h expected=0000", ptr);
        end

        // R4 R9: post-increment writes fill memory, wrapping past word 255.
        for (int i = 0; i < 256; i++) do_op(2'b10, 2'b10, 0, 0, 16'h0, 0, "R4_fill");
        do_op(2'b00, 2'b00, 0, 1, 16'h0000, 0, "R7_clear");
        do_op(2'b01, 2'b00, 0, 0, 16'h0, 1, "R3_word0");

        do_op(2'b00, 2'b00, 0, 1, 16'h0103, 0, "R7_plain");
        do_op(2'b10, 2'b10, 0, 0, 16'h0, 0, "R3_R4_push_up");
        do_op(2'b10, 2'b10, 0, 0, 16'h0, 0, "R4_second");
        do_op(2'b10, 2'b01, 0, 0, 16'h0, 0, "R5_predec_write");
        do_op(2'b01, 2'b00, 0, 0, 16'h0, 1, "R2_read_nomod");
        do_op(2'b10, 2'b11, 0, 0, 16'h0, 0, "R2_write_nomod");
        do_op(2'b00, 2'b01, 0, 0, 16'h0, 0, "R8_predec_idle");
        do_op(2'b11, 2'b10, 0, 0, 16'h0, 0, "R8_postinc_rsvd");
        do_op(2'b01, 2'b01, 1, 0, 16'h0, 1, "R6_pop_predec");
        do_op(2'b01, 2'b10, 1, 0, 16'h0, 1, "R6_load_postinc");
        do_op(2'b01, 2'b10, 0, 0, 16'h0, 1, "R4_read_postinc");
        do_op(2'b01, 2'b01, 0, 0, 16'h0, 1, "R5_read_predec");
        do_op(2'b10, 2'b01, 0, 1, 16'h2222, 0, "R7_alu_predec");
        do_op(2'b00, 2'b00, 0, 1, 16'h0101, 0, "R7_set");
        do_op(2'b01, 2'b00, 0, 0, 16'h0, 1, "R5_R7_addr_kept");
        do_op(2'b01, 2'b10, 1, 1, 16'h5A5A, 1, "R7_over_load");
        do_op(2'b00, 2'b00, 0, 1, 16'h0002, 0, "R9_set");
        do_op(2'b10, 2'b01, 0, 0, 16'h0, 0, "R9_predec_wrap");
        do_op(2'b01, 2'b00, 0, 0, 16'h0, 1, "R9_word255");
        do_op(2'b00, 2'b00, 0, 1, 16'h03FD, 0, "R9_set_top");
        do_op(2'b01, 2'b10, 0, 0, 16'h0, 1, "R9_postinc_wrap");
        do_op(2'b01, 2'b00, 0, 0, 16'h0, 1, "R9_word0");

        for (int i = 0; i < 2000; i++) begin
            logic [1:0] rc, rm;
            rc = 2'($urandom_range(0, 3));
            rm = 2'($urandom_range(0, 3));
            do_op(rc, rm, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                  16'($urandom), 1, "R2_R4_R5_R6_mix");
        end

        @(negedge clk);
        mem_cmd = 2'b00; stk_mode = 2'b00; rd_to_ptr = 1'b0; alu_we = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule